// File: doc/BRIEF.md
# Shadow Doorbell Configuration Unit

This block sits in the admin-command path of a queue-based storage controller. It handles the single admin command that places a shadow doorbell buffer and an event-index buffer in host memory. The block checks the two base addresses carried by the command and returns a completion status one cycle later. When it accepts a command, it keeps both bases and turns on shadow mode.

When shadow mode is on, the block tracks which I/O queues are bound to a shadow slot. Every submission and completion queue that is live when a command is accepted is bound at that moment. A queue whose live flag rises later is bound in the cycle after its flag rises. A lookup port takes a queue ID and a queue kind and returns the host addresses of that queue's doorbell slot and event-index slot. The slots for submission and completion queues sit at interleaved offsets, and the spacing comes from the controller's doorbell stride. The block moves no memory traffic and does not create queues. It only tells the neighbouring logic where the slots are.

Top module: `shadow_doorbell_cfg`

## Requirements
- R1: After a synchronous reset, `cpl_valid` is 0, `shadow_en` is 0 and every lookup returns `lk_valid` 0.
- R2: A command whose opcode is not 8'h7C completes with status 16'h4001 and leaves all state unchanged. Bit 14 is the do-not-retry flag and the low byte 8'h01 means invalid opcode.
- R3: A command with opcode 8'h7C completes with status 16'h4002 (do-not-retry plus code 8'h02, invalid field) in these cases, and leaves all state unchanged:
  - either base is zero;
  - either base has a nonzero bit below bit `pg_shift`.
- R4: Any other command with opcode 8'h7C completes with status 16'h0000, stores both bases and sets `shadow_en`. Each completion appears on `cpl_valid` on the clock edge that samples the command. `cpl_status` reads 0 whenever `cpl_valid` is 0.
- R5: The stride is 4 << `stride_exp` bytes. For a bound queue N:
  - the submission slot sits at base + 2·N·stride;
  - the completion slot sits at base + (2·N+1)·stride;
  - the same offset applies to both the doorbell base and the event-index base.
- R6: Queue ID 0 (the admin queue) never returns `lk_valid` 1.
- R7: On an accepted command, every queue with ID 1 to NUM_Q-1 whose live flag is set is bound on that same edge.
- R8: Once `shadow_en` is 1, a queue whose live flag rises is bound on the next edge. While `shadow_en` is 0, a live queue stays unbound.
- R9: A later accepted command overwrites both bases. All live queues then report addresses computed from the new bases.
- R10: A queue whose live flag is low is unbound and its lookup returns `lk_valid` 0 with both addresses 0.
- R11: `admin_caps` has bit 8 set and all other bits clear, which advertises the feature.
- R12: A lookup presented in one cycle is answered on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Admin command present this cycle |
| cmd_opcode | input | 8 | Admin opcode |
| cmd_db_base | input | ADDR_W | Proposed doorbell buffer base |
| cmd_ei_base | input | ADDR_W | Proposed event-index buffer base |
| pg_shift | input | PGS_W | log2 of the controller page size |
| stride_exp | input | SEXP_W | Doorbell stride exponent |
| sq_live | input | NUM_Q-1 | Submission queue exists, IDs 1..NUM_Q-1 |
| cq_live | input | NUM_Q-1 | Completion queue exists, IDs 1..NUM_Q-1 |
| lk_qid | input | QID_W | Lookup queue ID |
| lk_is_cq | input | 1 | Lookup is for a completion queue |
| lk_valid | output | 1 | Looked-up queue is bound |
| lk_db_addr | output | ADDR_W | Doorbell slot address, 0 when unbound |
| lk_ei_addr | output | ADDR_W | Event-index slot address, 0 when unbound |
| cpl_valid | output | 1 | Completion status present |
| cpl_status | output | 16 | Completion status |
| shadow_en | output | 1 | Shadow mode enabled |
| admin_caps | output | 16 | Optional admin command support field |

## Verification
Every result of this block appears one edge after its cause:
- the completion follows the command on that edge;
- the new bases and bindings are visible to a lookup presented after that edge;
- the answer to that lookup appears one edge later;
- a live-flag change shows in a lookup two edges after the flag changes.

The bench drives all inputs on the falling edge. A behavioural model updates on the rising edge from the inputs and from its own previous state. Outputs are compared on the next falling edge, which is the first point where each registered result is due. Directed checks use the same timing: each check is made after exactly one rising edge has followed the stimulus it depends on.

// File: rtl/shdb_pkg.sv
// Shared constants and types for the shadow doorbell configuration unit.
// Assumes a 16-bit completion status with the do-not-retry flag in bit 14.
package shdb_pkg;

    localparam logic [7:0]  OPC_SHADOW_CFG = 8'h7C;
    localparam logic [15:0] ST_OK          = 16'h0000;
    localparam logic [15:0] ST_BAD_OPCODE  = 16'h4001;
    localparam logic [15:0] ST_BAD_FIELD   = 16'h4002;
    localparam int          CAP_SHADOW_BIT = 8;

    // Result of decoding one admin command
    typedef struct packed {
        logic        accept;
        logic [15:0] status;
    } verdict_t;

endpackage

// File: rtl/shdb_cmd_check.sv
// Combinational decode of one admin command: opcode match plus checks that
// both bases are nonzero and aligned to the page size. Assumes the caller
// gates the verdict with its own command-valid strobe.
module shdb_cmd_check
    import shdb_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int PGS_W  = 6
) (
    input  logic [7:0]        opcode,
    input  logic [ADDR_W-1:0] db_base,
    input  logic [ADDR_W-1:0] ei_base,
    input  logic [PGS_W-1:0]  pg_shift,
    output verdict_t          verdict
);

    logic [ADDR_W-1:0] page_mask;
    logic              bad_base;

    // Low-bit mask for one page
    assign page_mask = (ADDR_W'(1) << pg_shift) - ADDR_W'(1);

    // Either base null or misaligned
    assign bad_base = (db_base == '0) || (ei_base == '0)
                   || ((db_base & page_mask) != '0)
                   || ((ei_base & page_mask) != '0);

    // Pick the completion status; only a clean command is accepted
    always_comb begin
        verdict.accept = 1'b0;
        verdict.status = ST_OK;
        if (opcode != OPC_SHADOW_CFG) begin
            verdict.status = ST_BAD_OPCODE;
        end else if (bad_base) begin
            verdict.status = ST_BAD_FIELD;
        end else begin
            verdict.accept = 1'b1;
        end
    end

endmodule

// File: rtl/shdb_base_store.sv
// Holds the two buffer bases and the shadow-enable flag. Reset clears all of
// them; a load overwrites both bases and sets the flag, which stays set.
module shdb_base_store #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] db_in,
    input  logic [ADDR_W-1:0] ei_in,
    output logic [ADDR_W-1:0] db_base,
    output logic [ADDR_W-1:0] ei_base,
    output logic              enabled
);

    // Capture bases on an accepted command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_base <= '0;
            ei_base <= '0;
            enabled <= 1'b0;
        end else if (load) begin
            db_base <= db_in;
            ei_base <= ei_in;
            enabled <= 1'b1;
        end
    end

endmodule

// File: rtl/shdb_bind_table.sv
// One bound bit per I/O submission and completion queue (IDs 1..NUM_Q-1).
// A queue is bound while it is live and shadow mode is on or being turned on
// this cycle. The admin queue has no entry. Assumes NUM_Q >= 2.
module shdb_bind_table #(
    parameter int NUM_Q = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             enabled,
    input  logic [NUM_Q-1:1] sq_live,
    input  logic [NUM_Q-1:1] cq_live,
    output logic [NUM_Q-1:1] sq_bound,
    output logic [NUM_Q-1:1] cq_bound
);

    logic bind_ok;

    // Binding allowed once bases exist or arrive now
    assign bind_ok = accept | enabled;

    for (genvar n = 1; n < NUM_Q; n++) begin : g_queue
        // Track binding of queue n in both directions
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sq_bound[n] <= 1'b0;
                cq_bound[n] <= 1'b0;
            end else begin
                sq_bound[n] <= sq_live[n] & bind_ok;
                cq_bound[n] <= cq_live[n] & bind_ok;
            end
        end
    end

endmodule

// File: rtl/shdb_slot_lookup.sv
// Registered lookup of a queue's shadow slot addresses. The slot index is
// 2*qid for a submission queue and 2*qid+1 for a completion queue, scaled by
// the stride 4 << stride_exp. Unbound queues return zeros.
module shdb_slot_lookup #(
    parameter int ADDR_W = 64,
    parameter int NUM_Q  = 8,
    parameter int SEXP_W = 4,
    parameter int QID_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [QID_W-1:0]  qid,
    input  logic              is_cq,
    input  logic [NUM_Q-1:1]  sq_bound,
    input  logic [NUM_Q-1:1]  cq_bound,
    input  logic [ADDR_W-1:0] db_base,
    input  logic [ADDR_W-1:0] ei_base,
    input  logic [SEXP_W-1:0] stride_exp,
    output logic              valid,
    output logic [ADDR_W-1:0] db_addr,
    output logic [ADDR_W-1:0] ei_addr
);

    localparam int SH_W = SEXP_W + 1;

    logic              hit;
    logic [ADDR_W-1:0] slot_idx;
    logic [SH_W-1:0]   byte_shift;
    logic [ADDR_W-1:0] offset;

    // Find the bound bit of the requested queue; ID 0 never matches
    always_comb begin
        hit = 1'b0;
        for (int n = 1; n < NUM_Q; n++) begin
            if (qid == QID_W'(n)) begin
                hit = is_cq ? cq_bound[n] : sq_bound[n];
            end
        end
    end

    // Interleaved slot index and its byte offset
    assign slot_idx   = ADDR_W'({qid, is_cq});
    assign byte_shift = SH_W'(stride_exp) + SH_W'(2);
    assign offset     = slot_idx << byte_shift;

    // Register the answer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid   <= 1'b0;
            db_addr <= '0;
            ei_addr <= '0;
        end else begin
            valid   <= hit;
            db_addr <= hit ? db_base + offset : '0;
            ei_addr <= hit ? ei_base + offset : '0;
        end
    end

endmodule

// File: rtl/shadow_doorbell_cfg.sv
// Shadow doorbell configuration unit. Decodes the buffer-setup admin
// command, stores the bases, binds live I/O queues to shadow slots and
// answers per-queue slot lookups. Assumes the live flags are driven by the
// queue-management logic and that stride and page size are static while
// a command is in flight.
module shadow_doorbell_cfg
    import shdb_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int NUM_Q  = 8,
    parameter int PGS_W  = 6,
    parameter int SEXP_W = 4,
    parameter int QID_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_opcode,
    input  logic [ADDR_W-1:0] cmd_db_base,
    input  logic [ADDR_W-1:0] cmd_ei_base,
    input  logic [PGS_W-1:0]  pg_shift,
    input  logic [SEXP_W-1:0] stride_exp,
    input  logic [NUM_Q-1:1]  sq_live,
    input  logic [NUM_Q-1:1]  cq_live,
    input  logic [QID_W-1:0]  lk_qid,
    input  logic              lk_is_cq,
    output logic              lk_valid,
    output logic [ADDR_W-1:0] lk_db_addr,
    output logic [ADDR_W-1:0] lk_ei_addr,
    output logic              cpl_valid,
    output logic [15:0]       cpl_status,
    output logic              shadow_en,
    output logic [15:0]       admin_caps
);

    verdict_t          verdict;
    logic              accept;
    logic [ADDR_W-1:0] db_base;
    logic [ADDR_W-1:0] ei_base;
    logic [NUM_Q-1:1]  sq_bound;
    logic [NUM_Q-1:1]  cq_bound;

    shdb_cmd_check #(.ADDR_W(ADDR_W), .PGS_W(PGS_W)) u_check (
        .opcode   (cmd_opcode),
        .db_base  (cmd_db_base),
        .ei_base  (cmd_ei_base),
        .pg_shift (pg_shift),
        .verdict  (verdict)
    );

    // Only a presented, clean command takes effect
    assign accept = cmd_valid & verdict.accept;

    shdb_base_store #(.ADDR_W(ADDR_W)) u_bases (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .db_in   (cmd_db_base),
        .ei_in   (cmd_ei_base),
        .db_base (db_base),
        .ei_base (ei_base),
        .enabled (shadow_en)
    );

    shdb_bind_table #(.NUM_Q(NUM_Q)) u_bind (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .enabled  (shadow_en),
        .sq_live  (sq_live),
        .cq_live  (cq_live),
        .sq_bound (sq_bound),
        .cq_bound (cq_bound)
    );

    shdb_slot_lookup #(
        .ADDR_W (ADDR_W),
        .NUM_Q  (NUM_Q),
        .SEXP_W (SEXP_W),
        .QID_W  (QID_W)
    ) u_lookup (
        .clk        (clk),
        .rst_n      (rst_n),
        .qid        (lk_qid),
        .is_cq      (lk_is_cq),
        .sq_bound   (sq_bound),
        .cq_bound   (cq_bound),
        .db_base    (db_base),
        .ei_base    (ei_base),
        .stride_exp (stride_exp),
        .valid      (lk_valid),
        .db_addr    (lk_db_addr),
        .ei_addr    (lk_ei_addr)
    );

    // Register the completion for every presented command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_valid  <= 1'b0;
            cpl_status <= ST_OK;
        end else begin
            cpl_valid  <= cmd_valid;
            cpl_status <= cmd_valid ? verdict.status : ST_OK;
        end
    end

    // Advertise the feature in the optional admin command field
    assign admin_caps = 16'(1) << CAP_SHADOW_BIT;

endmodule

// File: rtl/shadow_doorbell_cfg_chk.sv
// Temporal checks on the shadow doorbell configuration unit, bound to every
// instance of the top module.
module shadow_doorbell_cfg_chk
    import shdb_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int QID_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [QID_W-1:0]  lk_qid,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_db_addr,
    input logic              cpl_valid,
    input logic [15:0]       cpl_status,
    input logic              shadow_en
);

    // R4: each command is answered on the edge that samples it
    p_cpl_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> cpl_valid);

    // R4: a success completion goes with shadow mode on
    p_accept_sets_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_status == ST_OK) |-> shadow_en);

    // R2: status is always one of the three defined codes
    p_status_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> (cpl_status == ST_OK || cpl_status == ST_BAD_OPCODE
                       || cpl_status == ST_BAD_FIELD));

    // R3: a rejected command leaves shadow mode as it was
    p_reject_holds_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_status != ST_OK) |-> (shadow_en == $past(shadow_en)));

    // R6: the admin queue is never reported as bound
    p_admin_unbound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_qid == '0) |=> !lk_valid);

    // R7: a bound queue implies shadow mode is on
    p_bound_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> shadow_en);

    // R9: shadow mode stays on until reset
    p_en_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_en |=> shadow_en);

    // R5: a bound slot address is never null
    p_addr_nonnull_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_db_addr != '0));

endmodule

bind shadow_doorbell_cfg shadow_doorbell_cfg_chk #(
    .ADDR_W (ADDR_W),
    .QID_W  (QID_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .lk_qid     (lk_qid),
    .lk_valid   (lk_valid),
    .lk_db_addr (lk_db_addr),
    .cpl_valid  (cpl_valid),
    .cpl_status (cpl_status),
    .shadow_en  (shadow_en)
);

// File: tb/tb_shadow_doorbell_cfg.sv
module tb_shadow_doorbell_cfg;

    localparam int NQ = 8;
    localparam int AW = 64;
    localparam int QW = 3;
    localparam int PW = 6;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmd_valid;
    logic [7:0]    cmd_opcode;
    logic [AW-1:0] cmd_db_base;
    logic [AW-1:0] cmd_ei_base;
    logic [PW-1:0] pg_shift;
    logic [SW-1:0] stride_exp;
    logic [NQ-1:1] sq_live;
    logic [NQ-1:1] cq_live;
    logic [QW-1:0] lk_qid;
    logic          lk_is_cq;
    logic          lk_valid;
    logic [AW-1:0] lk_db_addr;
    logic [AW-1:0] lk_ei_addr;
    logic          cpl_valid;
    logic [15:0]   cpl_status;
    logic          shadow_en;
    logic [15:0]   admin_caps;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;

    always #5 clk = ~clk;

    shadow_doorbell_cfg dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .cmd_db_base(cmd_db_base), .cmd_ei_base(cmd_ei_base), .pg_shift(pg_shift),
        .stride_exp(stride_exp), .sq_live(sq_live), .cq_live(cq_live),
        .lk_qid(lk_qid), .lk_is_cq(lk_is_cq), .lk_valid(lk_valid),
        .lk_db_addr(lk_db_addr), .lk_ei_addr(lk_ei_addr), .cpl_valid(cpl_valid),
        .cpl_status(cpl_status), .shadow_en(shadow_en), .admin_caps(admin_caps)
    );

    task automatic chk(input bit ok, input string tag,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge
    bit                m_en;
    longint unsigned   m_db, m_ei;
    bit [NQ-1:0]       m_sqb, m_cqb;
    bit                e_cv, e_lv, e_en;
    logic [15:0]       e_st;
    longint unsigned   e_ldb, e_lei;
    int                e_q;
    bit                acc, b;
    int                q;
    longint unsigned   off, pm;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_db = 0; m_ei = 0; m_sqb = '0; m_cqb = '0;
            e_cv = 0; e_st = 16'h0; e_lv = 0; e_ldb = 0; e_lei = 0; e_q = 0; e_en = 0;
        end else begin
            q = int'(lk_qid);
            b = 0;
            if (q > 0 && q < NQ) b = lk_is_cq ? m_cqb[q] : m_sqb[q];
            off = longint'(2 * q + int'(lk_is_cq)) * (64'd4 << stride_exp);
            e_q = q;
            e_lv = b;
            e_ldb = b ? m_db + off : 0;
            e_lei = b ? m_ei + off : 0;
            acc = 0;
            e_cv = cmd_valid;
            e_st = 16'h0000;
            if (cmd_valid) begin
                pm = (64'd1 << pg_shift) - 64'd1;
                if (cmd_opcode != 8'h7C) e_st = 16'h4001;
                else if (cmd_db_base == 0 || cmd_ei_base == 0 ||
                         (cmd_db_base & pm) != 0 || (cmd_ei_base & pm) != 0)
                    e_st = 16'h4002;
                else acc = 1;
            end
            for (int n = 1; n < NQ; n++) begin
                m_sqb[n] = sq_live[n] && (acc || m_en);
                m_cqb[n] = cq_live[n] && (acc || m_en);
            end
            if (acc) begin
                m_en = 1; m_db = cmd_db_base; m_ei = cmd_ei_base;
            end
            e_en = m_en;
        end
    end

    // Per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(cpl_valid == e_cv, "R4 cpl_valid", cpl_valid, e_cv);
            chk(cpl_status == e_st,
                (e_st == 16'h4001) ? "R2 status" : (e_st == 16'h4002) ? "R3 status" : "R4 status",
                cpl_status, e_st);
            chk(shadow_en == e_en, "R4 shadow_en", shadow_en, e_en);
            chk(lk_valid == e_lv,
                e_lv ? "R5 lk_valid" : (e_q == 0) ? "R6 lk_valid" : "R10 lk_valid",
                lk_valid, e_lv);
            chk(lk_db_addr == e_ldb, e_lv ? "R5 db slot" : "R10 db slot", lk_db_addr, e_ldb);
            chk(lk_ei_addr == e_lei, e_lv ? "R5 ei slot" : "R10 ei slot", lk_ei_addr, e_lei);
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic [7:0] opc, input longint unsigned db,
                         input longint unsigned ei, input logic [15:0] exp_st,
                         input string tag);
        cmd_valid = 1; cmd_opcode = opc; cmd_db_base = db; cmd_ei_base = ei;
        step();
        cmd_valid = 0;
        chk(cpl_valid == 1'b1, tag, cpl_valid, 1);
        chk(cpl_status == exp_st, tag, cpl_status, exp_st);
    endtask

    task automatic look(input int qid, input bit cq, input bit ev,
                        input longint unsigned edb, input longint unsigned eei,
                        input string tag);
        lk_qid = QW'(qid); lk_is_cq = cq;
        step();
        chk(lk_valid == ev, tag, lk_valid, ev);
        chk(lk_db_addr == (ev ? edb : 0), tag, lk_db_addr, ev ? edb : 0);
        chk(lk_ei_addr == (ev ? eei : 0), tag, lk_ei_addr, ev ? eei : 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; cmd_valid = 0; cmd_opcode = 0; cmd_db_base = 0; cmd_ei_base = 0;
        pg_shift = 6'd12; stride_exp = 0; sq_live = '0; cq_live = '0;
        lk_qid = 1; lk_is_cq = 0;
        @(negedge clk);
        repeat (3) step();
        // R1: reset state
        chk(cpl_valid == 0, "R1 cpl_valid", cpl_valid, 0);
        chk(shadow_en == 0, "R1 shadow_en", shadow_en, 0);
        chk(lk_valid == 0, "R1 lk_valid", lk_valid, 0);
        // R11: feature advertised in bit 8
        chk(admin_caps == 16'h0100, "R11 caps", admin_caps, 16'h0100);
        rst_n = 1;
        cmp_on = 1;
        sq_live[1] = 1; sq_live[2] = 1; cq_live[1] = 1;
        step();
        // R8: live before enable stays unbound
        look(1, 0, 0, 0, 0, "R8 unbound before enable");
        issue(8'h06, 64'h10000, 64'h20000, 16'h4001, "R2 unknown opcode");
        chk(shadow_en == 0, "R2 state kept", shadow_en, 0);
        issue(8'h7C, 64'h0, 64'h20000, 16'h4002, "R3 null doorbell base");
        issue(8'h7C, 64'h10800, 64'h20000, 16'h4002, "R3 misaligned doorbell base");
        issue(8'h7C, 64'h10000, 64'h20004, 16'h4002, "R3 misaligned event base");
        chk(shadow_en == 0, "R3 state kept", shadow_en, 0);
        issue(8'h7C, 64'h10000, 64'h20000, 16'h0000, "R4 accepted");
        chk(shadow_en == 1, "R4 shadow_en", shadow_en, 1);
        // R7: queues live at accept bound at once; R12 one-cycle answer
        look(1, 0, 1, 64'h10008, 64'h20008, "R7 sq1 R12");
        look(2, 0, 1, 64'h10010, 64'h20010, "R7 sq2");
        look(1, 1, 1, 64'h1000C, 64'h2000C, "R5 cq1");
        look(0, 0, 0, 0, 0, "R6 admin sq");
        look(0, 1, 0, 0, 0, "R6 admin cq");
        look(2, 1, 0, 0, 0, "R10 cq2 absent");
        cq_live[2] = 1; sq_live[7] = 1;
        step();
        look(2, 1, 1, 64'h10014, 64'h20014, "R8 late cq2");
        look(7, 0, 1, 64'h10038, 64'h20038, "R5 sq7");
        stride_exp = 1;
        issue(8'h7C, 64'h40000, 64'h80000, 16'h0000, "R9 reconfig");
        look(2, 0, 1, 64'h40020, 64'h80020, "R9 sq2 rebased");
        look(1, 1, 1, 64'h40018, 64'h80018, "R9 cq1 rebased");
        issue(8'h7C, 64'h40000, 64'h0, 16'h4002, "R3 null event base");
        look(2, 0, 1, 64'h40020, 64'h80020, "R3 bases kept");
        sq_live[1] = 0;
        step();
        look(1, 0, 0, 0, 0, "R10 sq1 removed");
        step();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule